// File: doc/BRIEF.md
# LPC and Firmware-Hub Cycle Decoder

This block decides, for every host cycle, whether that cycle belongs on the LPC bus. It holds two enable registers. The first is a 16-bit I/O enable word whose bits switch on fixed legacy port pairs and port ranges. The second is an 8-bit firmware-hub enable byte whose top two bits switch on firmware memory windows and their register-space windows. One of these windows is also mirrored just below 1 MB. Software reads and writes both registers through a small configuration port that has byte enables.

Each cycle arrives as an I/O-or-memory flag and a 32-bit address. Three hit outputs answer it combinationally, in the same cycle. One says the cycle goes to LPC at all. One marks a firmware-memory hit. One marks a firmware register-space hit. The reset value of the firmware-hub byte is not fixed. It comes from a frame strap that is sampled on the rising edge of power-good, which tells the block whether a firmware hub is fitted.

Top module: `lpc_fwh_decode`

## Requirements
- R1: After rst_n is released and before any power-good rise, the I/O enable register reads 0000h and the firmware-hub register reads 00h.
- R2: On the first clock edge at which pwr_good is 1 after being 0, the firmware-hub register loads 00h if frame_strap is 1 and FFh if frame_strap is 0. It reads back the new value from the next cycle. A configuration write in the same cycle loses to this load.
- R3: cfg_sel=0 selects the I/O enable register and cfg_sel=1 selects the firmware-hub register. A write on cfg_we updates byte 0 when cfg_be[0]=1 and byte 1 when cfg_be[1]=1. cfg_rdata shows the selected register combinationally, and bits 15:8 read 0 when the firmware-hub register is selected.
- R4: Bits 15:13 of the I/O enable register always read 0, and writes to them are ignored.
- R5: With cyc_io=1, ports 4Eh and 4Fh hit when I/O bit 12 is set. Ports 2Eh and 2Fh hit when bit 11 is set.
- R6: With cyc_io=1, ports 62h and 66h hit when I/O bit 10 is set. Ports 60h and 64h hit when bit 8 is set. The neighbouring ports 61h, 63h and 65h never hit.
- R7: With cyc_io=1, ports 200h–20Fh hit when I/O bit 7 is set. Ports 388h–38Bh hit when bit 6 is set.
- R8: I/O decodes look only at address bits 15:0 and act only when cyc_io=1. A memory cycle (cyc_io=0) never makes an I/O hit.
- R9: When firmware-hub bit 7 is set and cyc_io=0, two windows assert hit_fwh: FFF80000h–FFFFFFFFh and the shadow window 000E0000h–000FFFFFh. The window FFB80000h–FFBFFFFFh asserts hit_reg.
- R10: When firmware-hub bit 6 is set and cyc_io=0, the window FFF00000h–FFF7FFFFh asserts hit_fwh. The window FFB00000h–FFB7FFFFh asserts hit_reg.
- R11: hit_lpc is the OR of every I/O hit, hit_fwh and hit_reg. All hit outputs are combinational from the current address, flag and register contents.
- R12: A decode whose enable bit is 0 produces no hit. I/O enable bits 9 and 5:0, and firmware-hub bits 5:0, are storage only and never cause a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Power-good level; its rising edge samples the strap |
| frame_strap | input | 1 | Frame pin strap level; 1 means no firmware hub is fitted |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Register select: 0 = I/O enables, 1 = firmware-hub enables |
| cfg_be | input | 2 | Byte enables for the write |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read data of the selected register |
| cyc_io | input | 1 | Cycle type: 1 = I/O, 0 = memory |
| cyc_addr | input | 32 | Cycle address |
| hit_lpc | output | 1 | Cycle is forwarded to LPC |
| hit_fwh | output | 1 | Firmware memory window hit |
| hit_reg | output | 1 | Firmware register-space window hit |

## Verification
The case that is hardest to reach is a power-good rise that lands in the same cycle as a configuration write to the firmware-hub register, since only this case shows which source wins. The bench gets there by holding pwr_good low through reset, issuing the write, and raising pwr_good on that same falling edge. It does this once with each strap level. It then sweeps addresses that sit exactly on each window edge and one step outside it: the ends of each firmware window, 1FFh/210h, 387h/38Ch, and the gaps 61h, 63h and 65h. It also sends I/O addresses with junk in the upper 16 bits.

// File: rtl/lpc_dec_pkg.sv
package lpc_dec_pkg;
  localparam int IO_W   = 16;
  localparam int FWH_W  = 8;
  localparam int ADDR_W = 32;
  localparam int PORT_W = 16;

  // Bits of the I/O enable register that hold state (15:13 are reserved)
  localparam logic [IO_W-1:0] IO_KEEP_MASK = 16'h1FFF;

  // Does a 16-bit port address match the fixed legacy decode tied to enable bit b?
  function automatic logic io_bit_hit(input int b, input logic [PORT_W-1:0] p);
    case (b)
      12: io_bit_hit = (p == 16'h004E) || (p == 16'h004F);
      11: io_bit_hit = (p == 16'h002E) || (p == 16'h002F);
      10: io_bit_hit = (p == 16'h0062) || (p == 16'h0066);
      8:  io_bit_hit = (p == 16'h0060) || (p == 16'h0064);
      7:  io_bit_hit = (p[15:4] == 12'h020);
      6:  io_bit_hit = (p[15:2] == 14'h00E2);
      default: io_bit_hit = 1'b0;
    endcase
  endfunction

  // Aligned window test: address bits above lsb equal a tag
  function automatic logic win_hit(input logic [ADDR_W-1:0] a, input int lsb,
                                   input logic [ADDR_W-1:0] tag);
    win_hit = ((a >> lsb) == tag);
  endfunction
endpackage

// File: rtl/lpc_cfg_regs.sv
module lpc_cfg_regs
  import lpc_dec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_good,
  input  logic             frame_strap,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [1:0]       cfg_be,
  input  logic [IO_W-1:0]  cfg_wdata,
  output logic [IO_W-1:0]  io_en,
  output logic [FWH_W-1:0] fwh_en,
  output logic             pg_rise
);
  logic pg_q;
  logic wr_io, wr_fwh;

  assign pg_rise = pwr_good & ~pg_q;
  assign wr_io   = cfg_we & ~cfg_sel;
  assign wr_fwh  = cfg_we &  cfg_sel & cfg_be[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pg_q <= 1'b0;
    else        pg_q <= pwr_good;
  end

  // I/O enables: byte-lane writes, reserved bits masked off
  genvar g;
  generate
    for (g = 0; g < IO_W/8; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          io_en[g*8 +: 8] <= '0;
        else if (wr_io && cfg_be[g])
          io_en[g*8 +: 8] <= cfg_wdata[g*8 +: 8] & IO_KEEP_MASK[g*8 +: 8];
      end
    end
  endgenerate

  // Firmware-hub enables: the strap load at the power-good rise beats a write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      fwh_en <= '0;
    else if (pg_rise)
      fwh_en <= frame_strap ? '0 : '1;
    else if (wr_fwh)
      fwh_en <= cfg_wdata[FWH_W-1:0];
  end
endmodule

// File: rtl/lpc_io_match.sv
module lpc_io_match
  import lpc_dec_pkg::*;
(
  input  logic [IO_W-1:0]   io_en,
  input  logic              cyc_io,
  input  logic [PORT_W-1:0] port,
  output logic              io_hit
);
  logic [IO_W-1:0] bit_hit;

  genvar i;
  generate
    for (i = 0; i < IO_W; i++) begin : g_bit
      assign bit_hit[i] = io_en[i] & io_bit_hit(i, port);
    end
  endgenerate

  assign io_hit = cyc_io & (|bit_hit);
endmodule

// File: rtl/lpc_mem_match.sv
module lpc_mem_match
  import lpc_dec_pkg::*;
(
  input  logic [1:0]        win_en,   // [1] = high 512 KB window, [0] = next 512 KB down
  input  logic              cyc_io,
  input  logic [ADDR_W-1:0] addr,
  output logic              fwh_hit,
  output logic              reg_hit
);
  localparam int BLK_LSB = 19;  // 512 KB granule
  localparam int SHD_LSB = 17;  // 128 KB shadow granule

  logic top_mem, top_shd, top_reg, low_mem, low_reg;

  assign top_mem = win_hit(addr, BLK_LSB, 32'h1FFF);
  assign top_shd = win_hit(addr, SHD_LSB, 32'h0007);
  assign top_reg = win_hit(addr, BLK_LSB, 32'h1FF7);
  assign low_mem = win_hit(addr, BLK_LSB, 32'h1FFE);
  assign low_reg = win_hit(addr, BLK_LSB, 32'h1FF6);

  assign fwh_hit = ~cyc_io & ((win_en[1] & (top_mem | top_shd)) | (win_en[0] & low_mem));
  assign reg_hit = ~cyc_io & ((win_en[1] & top_reg) | (win_en[0] & low_reg));
endmodule

// File: rtl/lpc_fwh_decode.sv
module lpc_fwh_decode
  import lpc_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              frame_strap,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [1:0]        cfg_be,
  input  logic [IO_W-1:0]   cfg_wdata,
  output logic [IO_W-1:0]   cfg_rdata,
  input  logic              cyc_io,
  input  logic [ADDR_W-1:0] cyc_addr,
  output logic              hit_lpc,
  output logic              hit_fwh,
  output logic              hit_reg
);
  logic [IO_W-1:0]  io_en;
  logic [FWH_W-1:0] fwh_en;
  logic             pg_rise;
  logic             io_hit;

  lpc_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .frame_strap(frame_strap),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .io_en(io_en), .fwh_en(fwh_en), .pg_rise(pg_rise)
  );

  lpc_io_match u_io (
    .io_en(io_en), .cyc_io(cyc_io), .port(cyc_addr[PORT_W-1:0]), .io_hit(io_hit)
  );

  lpc_mem_match u_mem (
    .win_en(fwh_en[FWH_W-1:FWH_W-2]), .cyc_io(cyc_io), .addr(cyc_addr),
    .fwh_hit(hit_fwh), .reg_hit(hit_reg)
  );

  assign cfg_rdata = cfg_sel ? {{(IO_W-FWH_W){1'b0}}, fwh_en} : io_en;
  assign hit_lpc   = io_hit | hit_fwh | hit_reg;
endmodule

// File: rtl/lpc_fwh_decode_chk.sv
module lpc_fwh_decode_chk
  import lpc_dec_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             pg_rise,
  input logic             frame_strap,
  input logic [IO_W-1:0]  io_en,
  input logic [FWH_W-1:0] fwh_en,
  input logic             cyc_io,
  input logic             io_hit,
  input logic             hit_lpc,
  input logic             hit_fwh,
  input logic             hit_reg
);
  assert_strap_absent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_rise && frame_strap) |=> (fwh_en == '0));

  assert_strap_present_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_rise && !frame_strap) |=> (fwh_en == '1));

  assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    io_en[15:13] == 3'b000);

  assert_io_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    io_hit |-> cyc_io);

  assert_mem_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_fwh || hit_reg) |-> !cyc_io);

  assert_lpc_covers_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (io_hit || hit_fwh || hit_reg) |-> hit_lpc);

  assert_disabled_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (fwh_en[7:6] == 2'b00) |-> (!hit_fwh && !hit_reg));
endmodule

bind lpc_fwh_decode lpc_fwh_decode_chk chk_i (
  .clk(clk), .rst_n(rst_n), .pg_rise(pg_rise), .frame_strap(frame_strap),
  .io_en(io_en), .fwh_en(fwh_en), .cyc_io(cyc_io), .io_hit(io_hit),
  .hit_lpc(hit_lpc), .hit_fwh(hit_fwh), .hit_reg(hit_reg)
);

// File: tb/lpc_fwh_decode_tb_top.sv
module lpc_fwh_decode_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwr_good = 1'b0;
  logic        frame_strap = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [1:0]  cfg_be = 2'b00;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        cyc_io = 1'b0;
  logic [31:0] cyc_addr = '0;
  logic        hit_lpc, hit_fwh, hit_reg;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  lpc_fwh_decode dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .frame_strap(frame_strap),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cyc_io(cyc_io), .cyc_addr(cyc_addr),
    .hit_lpc(hit_lpc), .hit_fwh(hit_fwh), .hit_reg(hit_reg)
  );

  // Behavioural reference state
  logic [15:0] m_io;
  logic [7:0]  m_fwh;
  logic        m_pg;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_io <= 16'h0000; m_fwh <= 8'h00; m_pg <= 1'b0;
    end else begin
      if (pwr_good && !m_pg) m_fwh <= frame_strap ? 8'h00 : 8'hFF;
      else if (cfg_we && cfg_sel && cfg_be[0]) m_fwh <= cfg_wdata[7:0];
      if (cfg_we && !cfg_sel) begin
        if (cfg_be[0]) m_io[7:0]  <= cfg_wdata[7:0];
        if (cfg_be[1]) m_io[15:8] <= {3'b000, cfg_wdata[12:8]};
      end
      m_pg <= pwr_good;
    end
  end

  function automatic bit in_rng(input logic [31:0] a, input logic [31:0] lo, input logic [31:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  function automatic bit exp_io();
    int p;
    bit h;
    p = int'(cyc_addr[15:0]);
    h = 0;
    if (m_io[12] && (p == 'h4E || p == 'h4F)) h = 1;
    if (m_io[11] && (p == 'h2E || p == 'h2F)) h = 1;
    if (m_io[10] && (p == 'h62 || p == 'h66)) h = 1;
    if (m_io[8]  && (p == 'h60 || p == 'h64)) h = 1;
    if (m_io[7]  && p >= 'h200 && p <= 'h20F) h = 1;
    if (m_io[6]  && p >= 'h388 && p <= 'h38B) h = 1;
    return cyc_io && h;
  endfunction

  function automatic bit exp_fwh();
    if (cyc_io) return 0;
    return (m_fwh[7] && (in_rng(cyc_addr, 32'hFFF80000, 32'hFFFFFFFF) ||
                         in_rng(cyc_addr, 32'h000E0000, 32'h000FFFFF))) ||
           (m_fwh[6] && in_rng(cyc_addr, 32'hFFF00000, 32'hFFF7FFFF));
  endfunction

  function automatic bit exp_reg();
    if (cyc_io) return 0;
    return (m_fwh[7] && in_rng(cyc_addr, 32'hFFB80000, 32'hFFBFFFFF)) ||
           (m_fwh[6] && in_rng(cyc_addr, 32'hFFB00000, 32'hFFB7FFFF));
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Compare all outputs against the model, mid-cycle
  task automatic compare(input string tag);
    logic [15:0] er;
    er = cfg_sel ? {8'h00, m_fwh} : m_io;
    check(tag, "cfg_rdata", 32'(cfg_rdata), 32'(er));
    check(tag, "hit_fwh", 32'(hit_fwh), 32'(exp_fwh()));
    check(tag, "hit_reg", 32'(hit_reg), 32'(exp_reg()));
    check(tag, "hit_lpc", 32'(hit_lpc), 32'(exp_io() || exp_fwh() || exp_reg()));
  endtask

  task automatic step(input string tag);
    #5 compare(tag);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wr(input bit sel, input logic [1:0] be, input logic [15:0] d, input string tag);
    cfg_we = 1'b1; cfg_sel = sel; cfg_be = be; cfg_wdata = d;
    step(tag);
  endtask

  task automatic rd(input bit sel, input string tag);
    cfg_sel = sel; step(tag);
  endtask

  task automatic cyc(input bit io, input logic [31:0] a, input string tag);
    cyc_io = io; cyc_addr = a; step(tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pwr_good = 1'b0; cfg_we = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic io_sweep(input string tag);
    foreach (io_list[k]) cyc(1'b1, io_list[k], tag);
  endtask

  task automatic mem_sweep(input string tag);
    foreach (mem_list[k]) cyc(1'b0, mem_list[k], tag);
  endtask

  logic [31:0] io_list[$] = '{32'h4E, 32'h4F, 32'h4D, 32'h50, 32'h2E, 32'h2F, 32'h30,
                              32'h60, 32'h61, 32'h62, 32'h63, 32'h64, 32'h65, 32'h66,
                              32'h1FF, 32'h200, 32'h20F, 32'h210, 32'h387, 32'h388,
                              32'h38B, 32'h38C, 32'hABCD0060, 32'hFFFF0388};
  logic [31:0] mem_list[$] = '{32'hFFF80000, 32'hFFFFFFFF, 32'hFFF7FFFF, 32'hFFF00000,
                               32'hFFEFFFFF, 32'h000E0000, 32'h000FFFFF, 32'h000DFFFF,
                               32'h00100000, 32'hFFB80000, 32'hFFBFFFFF, 32'hFFB7FFFF,
                               32'hFFB00000, 32'hFFAFFFFF, 32'hFFC00000, 32'h00000060};

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset values
    rd(1'b0, "R1"); rd(1'b1, "R1");
    // R2 strap low: present -> FFh
    frame_strap = 1'b0; pwr_good = 1'b1; step("R2");
    rd(1'b1, "R2");
    // R3 full write and byte-lane writes; R4 reserved bits
    wr(1'b0, 2'b11, 16'hFFFF, "R4"); rd(1'b0, "R4");
    wr(1'b0, 2'b01, 16'h0000, "R3"); rd(1'b0, "R3");
    wr(1'b0, 2'b10, 16'hE5A5, "R3"); rd(1'b0, "R3");
    wr(1'b1, 2'b10, 16'h0000, "R3"); rd(1'b1, "R3");
    wr(1'b1, 2'b01, 16'hFF3C, "R3"); rd(1'b1, "R3");
    // All I/O enables on, both firmware windows on
    wr(1'b0, 2'b11, 16'h1FFF, "R5"); wr(1'b1, 2'b01, 16'h00C0, "R9");
    io_sweep("R5"); io_sweep("R6"); io_sweep("R7");
    mem_sweep("R9"); mem_sweep("R10");
    // R8: I/O decode on memory flag, memory decode on I/O flag
    foreach (io_list[k]) cyc(1'b0, io_list[k], "R8");
    foreach (mem_list[k]) cyc(1'b1, mem_list[k], "R8");
    // R11 single-enable patterns
    wr(1'b0, 2'b11, 16'h1000, "R11"); io_sweep("R11");
    wr(1'b0, 2'b11, 16'h0500, "R6"); io_sweep("R6");
    wr(1'b0, 2'b11, 16'h0080, "R7"); io_sweep("R7");
    wr(1'b1, 2'b01, 16'h0080, "R9"); mem_sweep("R9");
    wr(1'b1, 2'b01, 16'h0040, "R10"); mem_sweep("R10");
    // R12 storage-only bits and all-off
    wr(1'b0, 2'b11, 16'h023F, "R12"); io_sweep("R12");
    wr(1'b1, 2'b01, 16'h003F, "R12"); mem_sweep("R12");
    wr(1'b0, 2'b11, 16'h0000, "R12"); io_sweep("R12");
    // R2 strap high with a same-cycle write that must lose
    do_reset();
    frame_strap = 1'b1; pwr_good = 1'b1;
    wr(1'b1, 2'b01, 16'h00C0, "R2");
    rd(1'b1, "R2"); mem_sweep("R2");
    // R2 strap low with a same-cycle write of 00h
    do_reset();
    frame_strap = 1'b0; pwr_good = 1'b1;
    wr(1'b1, 2'b01, 16'h0000, "R2");
    rd(1'b1, "R2"); mem_sweep("R2");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule